// File: doc/BRIEF.md
# Segmented Flash Program/Erase Controller

This block stands between a processor-side command port and a behavioural flash array held in on-chip registers. It takes byte, 16-bit and 32-bit program commands, erase commands for one segment, and an erase command for the whole main region. Programming follows flash rules: a write can only clear bits. An erase returns every byte of its target to 0xFF.

The address space has two regions. The main region is a run of equal 512-byte segments. Above it sits a small information region of four 128-byte segments, named A to D from the lowest address. A level input locks segment A. While it is high, no program or erase may change segment A, and the other segments are not affected by it.

Every accepted command keeps the block busy for a fixed, parameterised number of cycles. At the end a one-cycle done pulse marks completion. A command that is refused raises a one-cycle violation pulse and changes nothing. A command is refused when it is misaligned, out of range, of an unknown type, aimed at a locked segment A, or issued while busy. A combinational byte read port shows the array contents.

Top module: `flash_seg_ctl`

## Requirements
- R1: After reset, busy, done and viol are low and every byte of the array reads 0xFF.
- R2: Addresses 0 to MAIN_SEGS*512-1 are the main region, in 512-byte segments. The next 4*128 bytes are information segments A, B, C and D, in that order from low to high. rd_data returns the byte at rd_addr, or 0xFF when rd_addr is beyond the map.
- R3: cmd_op encodes 0 = byte write, 1 = 16-bit write and 2 = 32-bit write. Lane k of cmd_wdata (bits 8k+7:8k) goes to byte cmd_addr+k. Each written byte becomes old AND new.
- R4: cmd_op 3 erases the single segment that contains cmd_addr, main or information, to 0xFF. It leaves every other byte unchanged.
- R5: cmd_op 4 sets every main-region byte to 0xFF. It ignores cmd_addr and never changes information segments A to D.
- R6: While lock_a is high, a write or segment erase whose address lies in segment A is refused. Writes and erases to segments B to D, and mass erase, still proceed.
- R7: A 16-bit write with cmd_addr bit 0 set, or a 32-bit write with cmd_addr bits 1:0 not zero, is refused.
- R8: cmd_op values 5 to 7 are refused. A write or segment erase with cmd_addr at or beyond the end of the map is also refused.
- R9: An accepted command raises busy on the next cycle and holds it for exactly OP_CYCLES cycles. done pulses for one cycle as busy falls. The array shows the result from that cycle and is unchanged before it.
- R10: A command presented while busy is ignored and raises viol on the next cycle. The running operation is unaffected.
- R11: Every refused command gives a one-cycle viol pulse on the next cycle, without busy. An accepted command never raises viol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command type |
| cmd_addr | input | AW (11) | Byte address of the command |
| cmd_wdata | input | 32 | Write data, byte lane k for address+k |
| lock_a | input | 1 | Lock for information segment A |
| rd_addr | input | AW (11) | Read byte address |
| rd_data | output | 8 | Byte at rd_addr |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| viol | output | 1 | One-cycle refusal pulse |

## Verification
The bench fills the whole array with 32-bit writes, then erases every segment in turn and compares all bytes against a model after each step. A decoder that used the wrong segment size at the main/information boundary would wipe a neighbour, or leave part of its own segment untouched. Mass erase is issued with segment A locked and with an out-of-range address. A design that ran past the main region, or honoured the address, would change information bytes or refuse the command. The bench also covers AND-only programming over repeated writes, misaligned 16- and 32-bit writes, bad opcodes, and a second command issued during busy. Each of these must leave the array exactly unchanged. An early update, or a done pulse that is off by one cycle, shows in the busy-length and mid-operation read checks.

// File: rtl/flash_seg_ctl.sv
`timescale 1ns/1ps
module flash_seg_ctl #(
  parameter int MAIN_SEGS      = 2,
  parameter int MAIN_SEG_BYTES = 512,
  parameter int INFO_SEG_BYTES = 128,
  parameter int OP_CYCLES      = 4,
  localparam int INFO_SEGS  = 4,
  localparam int MAIN_BYTES = MAIN_SEGS * MAIN_SEG_BYTES,
  localparam int TOTAL      = MAIN_BYTES + INFO_SEGS * INFO_SEG_BYTES,
  localparam int AW         = $clog2(TOTAL),
  localparam int CW         = $clog2(OP_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [31:0]   cmd_wdata,
  input  logic          lock_a,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic          viol
);
  localparam logic [AW:0] L_MAIN  = (AW+1)'(MAIN_BYTES);
  localparam logic [AW:0] L_AEND  = (AW+1)'(MAIN_BYTES + INFO_SEG_BYTES);
  localparam logic [AW:0] L_TOTAL = (AW+1)'(TOTAL);
  localparam logic [AW:0] M_MASK  = ~((AW+1)'(MAIN_SEG_BYTES - 1));
  localparam logic [AW:0] I_MASK  = ~((AW+1)'(INFO_SEG_BYTES - 1));
  localparam logic [AW:0] M_SIZE  = (AW+1)'(MAIN_SEG_BYTES);
  localparam logic [AW:0] I_SIZE  = (AW+1)'(INFO_SEG_BYTES);

  logic [7:0]    mem [TOTAL];
  logic [2:0]    op_q;
  logic [AW:0]   addr_q;
  logic [31:0]   data_q;
  logic [CW-1:0] cnt;

  wire [AW:0] ca      = {1'b0, cmd_addr};
  wire is_mass        = cmd_op == 3'd4;
  wire op_bad         = cmd_op > 3'd4;
  wire out_rng        = !is_mass && ca >= L_TOTAL;
  wire misalign       = (cmd_op == 3'd1 && cmd_addr[0]) ||
                        (cmd_op == 3'd2 && cmd_addr[1:0] != 2'b00);
  wire locked         = lock_a && !is_mass && ca >= L_MAIN && ca < L_AEND;
  wire bad            = op_bad || out_rng || misalign || locked;
  wire accept         = cmd_valid && !busy && !bad;
  wire finish         = busy && cnt == '0;

  wire wr_en          = finish && op_q <= 3'd2;
  wire er_en          = finish && (op_q == 3'd3 || op_q == 3'd4);
  wire q_info         = addr_q >= L_MAIN;
  wire [AW:0] wr_hi   = addr_q + (op_q == 3'd0 ? (AW+1)'(1) :
                                  op_q == 3'd1 ? (AW+1)'(2) : (AW+1)'(4));
  wire [AW:0] er_lo   = op_q == 3'd4 ? '0 :
                        q_info ? (addr_q & I_MASK) : (addr_q & M_MASK);
  wire [AW:0] er_hi   = op_q == 3'd4 ? L_MAIN :
                        er_lo + (q_info ? I_SIZE : M_SIZE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      viol   <= 1'b0;
      cnt    <= '0;
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      done <= finish;
      viol <= cmd_valid && (busy || bad);
      if (accept) begin
        busy   <= 1'b1;
        cnt    <= CW'(OP_CYCLES - 1);
        op_q   <= cmd_op;
        addr_q <= ca;
        data_q <= cmd_wdata;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < TOTAL; i++) begin
        if (er_en && (AW+1)'(i) >= er_lo && (AW+1)'(i) < er_hi)
          mem[i] <= 8'hFF;
        else if (wr_en && (AW+1)'(i) >= addr_q && (AW+1)'(i) < wr_hi)
          mem[i] <= mem[i] & 8'(data_q >> (8 * ((i - int'(addr_q)) & 3)));
      end
    end
  end

  assign rd_data = ({1'b0, rd_addr} < L_TOTAL) ? mem[rd_addr] : 8'hFF;
endmodule

module flash_seg_ctl_chk #(
  parameter int OP_CYCLES  = 4,
  parameter int MAIN_BYTES = 1024,
  parameter int SEGA_BYTES = 128,
  parameter int AW         = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic [AW-1:0] cmd_addr,
  input logic          lock_a,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic          busy,
  input logic          done,
  input logic          viol
);
  int bcnt;
  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= 0;
    else        bcnt <= busy ? bcnt + 1 : 0;
  end

  wire seg_a = int'(cmd_addr) >= MAIN_BYTES && int'(cmd_addr) < MAIN_BYTES + SEGA_BYTES;

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < OP_CYCLES);
  // R9
  done_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && bcnt == OP_CYCLES));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  quiet_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $stable(rd_addr)) |-> $stable(rd_data));
  // R10
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && bcnt < OP_CYCLES - 1) |=> (viol && busy));
  // R6
  lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && lock_a && seg_a && cmd_op != 3'd4) |=> (viol && !busy));
  // R7
  align_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd1 && cmd_addr[0]) |=> (viol && !busy));
  // R11
  viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !$past(cmd_valid)) |-> 1'b0);
  // R11
  start_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !viol);
endmodule

bind flash_seg_ctl flash_seg_ctl_chk #(
  .OP_CYCLES(OP_CYCLES), .MAIN_BYTES(MAIN_BYTES), .SEGA_BYTES(INFO_SEG_BYTES), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .lock_a(lock_a), .rd_addr(rd_addr), .rd_data(rd_data),
  .busy(busy), .done(done), .viol(viol)
);

// File: tb/test_flash_seg_ctl.sv
`timescale 1ns/1ps
module test_flash_seg_ctl;
  localparam int MSEGS = 2, MSB = 512, ISB = 128, OPC = 4;
  localparam int MAIN = MSEGS * MSB;
  localparam int TOTAL = MAIN + 4 * ISB;
  localparam int AW = $clog2(TOTAL);

  logic clk = 0, rst_n = 0, cmd_valid = 0, lock_a = 0;
  logic [2:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0, rd_addr = 0;
  logic [31:0] cmd_wdata = 0;
  logic [7:0] rd_data;
  logic busy, done, viol;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] model [TOTAL];

  always #4 clk = ~clk;

  flash_seg_ctl #(.MAIN_SEGS(MSEGS), .MAIN_SEG_BYTES(MSB), .INFO_SEG_BYTES(ISB), .OP_CYCLES(OPC))
    i_flash_seg_ctl (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .lock_a(lock_a), .rd_addr(rd_addr),
      .rd_data(rd_data), .busy(busy), .done(done), .viol(viol));

  task automatic chk(input bit c, input string req, input longint act, input longint exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_apply(input int op, input int a, input logic [31:0] d);
    int lo, n;
    case (op)
      0, 1, 2: begin
        n = (op == 0) ? 1 : (op == 1) ? 2 : 4;
        for (int k = 0; k < n; k++) model[a+k] = model[a+k] & d[8*k +: 8];
      end
      3: begin
        if (a < MAIN) begin lo = (a / MSB) * MSB; n = MSB; end
        else          begin lo = (a / ISB) * ISB; n = ISB; end
        for (int k = lo; k < lo + n; k++) model[k] = 8'hFF;
      end
      default: for (int k = 0; k < MAIN; k++) model[k] = 8'hFF;
    endcase
  endtask

  task automatic compare_all(input string req);
    int bad = 0, first = -1;
    logic [7:0] fa = 0;
    for (int a = 0; a < TOTAL; a++) begin
      rd_addr = AW'(a);
      #0.1;
      if (rd_data !== model[a]) begin
        if (first < 0) begin first = a; fa = rd_data; end
        bad++;
      end
    end
    chk(bad == 0, req, (first < 0) ? 0 : {first, fa}, (first < 0) ? 0 : {first, model[first]});
  endtask

  task automatic cmd(input int op, input int a, input logic [31:0] d, input bit ok, input string req);
    int n = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = AW'(a); cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0;
    if (ok) begin
      chk(busy === 1 && viol === 0, {req, " R11 accept"}, {busy, viol}, 2'b10);
      while (busy === 1 && n < 1000) begin n++; @(negedge clk); end
      chk(n == OPC, "R9 busy length", n, OPC);
      chk(done === 1, "R9 done pulse", done, 1);
      model_apply(op, a, d);
      @(negedge clk);
      chk(done === 0, "R9 done one cycle", done, 0);
    end else begin
      chk(viol === 1 && busy === 0, {req, " R11 refuse"}, {busy, viol}, 2'b01);
      @(negedge clk);
      chk(viol === 0, "R11 viol one cycle", viol, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", 0, 1);
    if (!finished) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < TOTAL; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && done === 0 && viol === 0, "R1 flags", {busy, done, viol}, 0);
    compare_all("R1 erased array");
    rd_addr = AW'(TOTAL + 5); #0.1;
    chk(rd_data === 8'hFF, "R2 read beyond map", rd_data, 8'hFF);

    // R3 AND-only programming, lane order
    cmd(0, 3, 32'h0000_000F, 1, "R3 byte");
    cmd(0, 3, 32'hFFFF_FFF3, 1, "R3 byte again");
    rd_addr = 3; #0.1;
    chk(rd_data === 8'h03, "R3 AND result", rd_data, 8'h03);
    cmd(1, 10, 32'h0000_1234, 1, "R3 word");
    cmd(2, 20, 32'h8765_4321, 1, "R3 long");
    cmd(2, 20, 32'hF0F0_F0F0, 1, "R3 long again");
    cmd(1, MAIN + 2 * ISB, 32'h0000_A55A, 1, "R3 word info C");
    compare_all("R3 writes");

    // R7 alignment, R8 range and opcode
    cmd(1, 31, 32'h0, 0, "R7 odd word");
    cmd(2, 34, 32'h0, 0, "R7 long off by 2");
    cmd(2, 37, 32'h0, 0, "R7 long off by 1");
    cmd(0, TOTAL + 1, 32'h0, 0, "R8 byte out of range");
    cmd(3, TOTAL, 32'h0, 0, "R8 erase out of range");
    for (int op = 5; op < 8; op++) cmd(op, 40, 32'h0, 0, "R8 bad op");
    compare_all("R7 R8 array unchanged");

    // R10 command while busy, R9 no early update
    @(negedge clk);
    cmd_valid = 1; cmd_op = 0; cmd_addr = AW'(100); cmd_wdata = 32'h0;
    @(negedge clk);
    cmd_addr = AW'(200);
    @(negedge clk);
    cmd_valid = 0;
    chk(viol === 1 && busy === 1, "R10 refuse while busy", {busy, viol}, 2'b11);
    rd_addr = 100; #0.1;
    chk(rd_data === model[100], "R9 unchanged during busy", rd_data, model[100]);
    while (busy === 1) @(negedge clk);
    chk(done === 1, "R10 running op completes", done, 1);
    model_apply(0, 100, 32'h0);
    compare_all("R10 second command ignored");

    // fill array with long writes
    for (int a = 0; a < TOTAL; a += 4)
      cmd(2, a, 32'(a * 32'h9E37_79B1) | 32'h0101_0101, 1, "R3 fill");
    compare_all("R3 filled array");

    // R4 each segment erase, address inside segment
    for (int s = 0; s < MSEGS; s++) begin
      cmd(3, s * MSB + 77, 32'h0, 1, "R4 main erase");
      compare_all("R4 main segment");
    end
    for (int s = 0; s < 4; s++) begin
      cmd(2, MAIN + s * ISB, 32'h0, 1, "R4 mark info");
    end
    for (int a = 0; a < MAIN; a += 4) cmd(2, a, 32'h0F0F_0F0F, 1, "R4 refill");
    cmd(3, MAIN + ISB + ISB - 1, 32'h0, 1, "R4 erase B top byte");
    compare_all("R4 info segment B only");
    cmd(3, MAIN + 3 * ISB, 32'h0, 1, "R4 erase D");
    compare_all("R4 info segment D only");

    // R6 lock on segment A
    lock_a = 1;
    cmd(0, MAIN + 9, 32'h0, 0, "R6 locked write A");
    cmd(3, MAIN, 32'h0, 0, "R6 locked erase A");
    cmd(2, MAIN + ISB - 4, 32'h0, 0, "R6 locked long A top");
    cmd(0, MAIN + ISB, 32'h0, 1, "R6 write B while locked");
    cmd(3, MAIN + 2 * ISB, 32'h0, 1, "R6 erase C while locked");
    compare_all("R6 segment A intact");

    // R5 mass erase ignores address, spares info
    cmd(4, TOTAL + 100, 32'h0, 1, "R5 mass erase");
    compare_all("R5 main erased info kept");

    lock_a = 0;
    cmd(3, MAIN + 50, 32'h0, 1, "R6 erase A unlocked");
    cmd(0, MAIN + 1, 32'h0000_0055, 1, "R6 write A unlocked");
    compare_all("R6 unlocked A");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule